// File: doc/BRIEF.md
# Low-Power Read Turnaround Timer

After the link controller has sent a low-power packet that expects an answer, this block runs the bus turnaround. Such packets are a read request or a write that enables the tearing-effect report. The block waits a programmed hold interval and then raises a turnaround request toward the PHY. While the request is up, it watches for the link direction to reverse. After the reversal it watches the receive side until valid data appears. All intervals are counted in escape-clock ticks. A tick is a one-cycle enable in the system clock domain.

Each of the two watch phases has its own timeout limit. An expiry drops the request, sets a sticky status bit and sends the block back to idle. A normal finish gives a one-cycle completion pulse. The block has four states: IDLE, HOLD, TURN and LISTEN. Its named transitions are:

- ACCEPT (IDLE to HOLD)
- HOLD_DONE (HOLD to TURN)
- DIR_SEEN (TURN to LISTEN)
- TURN_EXPIRE (TURN to IDLE)
- DATA_SEEN (LISTEN to IDLE)
- LISTEN_EXPIRE (LISTEN to IDLE)

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: After reset, busy, turn_req, xfer_done, turn_expired and listen_expired are all 0.
- R2: A cycle with pkt_done=1 and pkt_needs_ta=1 while idle enters HOLD on that edge. turn_req rises on the first edge at which the number of ticks counted in HOLD equals hold_count. A tick counts when it is sampled on an edge at which the block stays in HOLD. With hold_count=0, turn_req rises on the second edge after the strobe.
- R3: A pkt_done strobe with pkt_needs_ta=0 starts nothing; busy stays 0.
- R4: turn_req stays 1 until an edge samples link_reversed=1. It falls on that edge and the block enters LISTEN.
- R5: In TURN, if the count of ticks reaches turn_limit while link_reversed is 0, then on the next edge turn_req falls, turn_expired is set and the block goes idle with no xfer_done. A direction change on that same edge takes priority over the expiry. With turn_limit=0 the expiry happens on the first TURN edge.
- R6: In LISTEN, ticks count only while rx_lp_mode=1 and rx_data_valid=0. The count restarts whenever rx_lp_mode is 0. If the count reaches listen_limit on an edge where rx_lp_mode=1 and rx_data_valid=0, listen_expired is set and the block goes idle with no xfer_done.
- R7: In LISTEN, an edge with rx_lp_mode=1 and rx_data_valid=1 ends the sequence. xfer_done is 1 for exactly the following cycle and busy falls on that same edge.
- R8: busy is 1 from the ACCEPT edge until the edge that returns the block to IDLE. Any pkt_done strobe seen while busy is ignored.
- R9: turn_expired and listen_expired hold their value until cleared. status_clr bit 0 clears turn_expired and status_clr bit 1 clears listen_expired, one edge after the bit is written as 1. If a set and a clear of the same bit fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esc_tick | input | 1 | One-cycle escape-clock tick enable |
| pkt_done | input | 1 | Strobe: a low-power packet has finished transmission |
| pkt_needs_ta | input | 1 | Qualifies pkt_done: the packet expects a turnaround |
| hold_count | input | HOLD_W (16) | Ticks to wait between packet end and the turnaround request |
| turn_limit | input | TURN_W (8) | Tick limit for the link direction to reverse |
| listen_limit | input | LISTEN_W (16) | Tick limit for receive data to become valid in receive mode |
| link_reversed | input | 1 | PHY reports that the link direction has reversed |
| rx_lp_mode | input | 1 | PHY reports low-power receive mode |
| rx_data_valid | input | 1 | PHY reports valid receive data |
| status_clr | input | 2 | Write-one-to-clear: bit 0 turn_expired, bit 1 listen_expired |
| turn_req | output | 1 | Turnaround request toward the PHY |
| busy | output | 1 | A turnaround sequence is in progress |
| xfer_done | output | 1 | One-cycle pulse on successful completion |
| turn_expired | output | 1 | Sticky: the direction change timed out |
| listen_expired | output | 1 | Sticky: receive data validity timed out |

## Verification
The hardest situation to reach from the ports is a race at the limit edge. In one case the direction change arrives on the very edge where the turnaround count meets its limit. In the other, valid data arrives on the edge where the receive count meets its limit. A related race is a status clear that lands on the same edge as a new expiry. The stimulus draws small limits, random tick spacing and random direction and data delays for many sequences, so these coincidences occur often. A cycle-level expectation derived from the requirements judges every edge. A directed sequence holds the clear bit high through a forced expiry.

// File: rtl/lpta_pkg.sv
package lpta_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HOLD   = 2'd1,
        PH_TURN   = 2'd2,
        PH_LISTEN = 2'd3
    } lpta_phase_e;

    localparam int STATUS_BITS = 2;
    localparam int ST_TURN     = 0;
    localparam int ST_LISTEN   = 1;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lpta_interval_timer.sv
module lpta_interval_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         at_limit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == limit);

    // the count only ever restarts or advances by one tick
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lpta_sequencer.sv
module lpta_sequencer
    import lpta_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        esc_tick,
    input  logic        pkt_done,
    input  logic        pkt_needs_ta,
    input  logic        link_reversed,
    input  logic        rx_lp_mode,
    input  logic        rx_data_valid,
    input  logic        at_limit,
    output lpta_phase_e phase,
    output logic        cnt_clr,
    output logic        cnt_step,
    output logic        turn_req,
    output logic        busy,
    output logic        xfer_done,
    output logic        turn_expire,
    output logic        listen_expire
);

    lpta_phase_e ph_q, ph_d;
    logic        done_q;
    logic        data_seen;
    logic        rx_waiting;

    assign data_seen  = rx_lp_mode && rx_data_valid;
    assign rx_waiting = rx_lp_mode && !rx_data_valid;

    // next-state decision
    always_comb begin
        ph_d          = ph_q;
        turn_expire   = 1'b0;
        listen_expire = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (pkt_done && pkt_needs_ta) ph_d = PH_HOLD;        // ACCEPT
            end
            PH_HOLD: begin
                if (at_limit) ph_d = PH_TURN;                         // HOLD_DONE
            end
            PH_TURN: begin
                if (link_reversed) begin
                    ph_d = PH_LISTEN;                                 // DIR_SEEN
                end else if (at_limit) begin
                    ph_d        = PH_IDLE;                            // TURN_EXPIRE
                    turn_expire = 1'b1;
                end
            end
            PH_LISTEN: begin
                if (data_seen) begin
                    ph_d = PH_IDLE;                                   // DATA_SEEN
                end else if (rx_waiting && at_limit) begin
                    ph_d          = PH_IDLE;                          // LISTEN_EXPIRE
                    listen_expire = 1'b1;
                end
            end
        endcase
    end

    // counter control: restart on every phase change and while receive mode is off
    always_comb begin
        cnt_clr  = (ph_d != ph_q) || (ph_q == PH_LISTEN && !rx_lp_mode);
        cnt_step = 1'b0;
        unique case (ph_q)
            PH_IDLE:   cnt_step = 1'b0;
            PH_HOLD:   cnt_step = esc_tick && !at_limit;
            PH_TURN:   cnt_step = esc_tick && !at_limit;
            PH_LISTEN: cnt_step = esc_tick && !at_limit && rx_waiting;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            done_q <= (ph_q == PH_LISTEN) && data_seen;
        end
    end

    // outputs
    always_comb begin
        phase     = ph_q;
        turn_req  = (ph_q == PH_TURN);
        busy      = (ph_q != PH_IDLE);
        xfer_done = done_q;
    end

    // the listen phase is only ever entered from the request phase
    assert_listen_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LISTEN && $past(ph_q) != PH_LISTEN) |-> $past(ph_q) == PH_TURN);

    // a hold phase always starts from idle
    assert_hold_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD && $past(ph_q) != PH_HOLD) |-> $past(ph_q) == PH_IDLE);

endmodule

// File: rtl/lpta_sticky_status.sv
module lpta_sticky_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
            end else if (set[i]) begin
                flag[i] <= 1'b1;
            end else if (clr[i]) begin
                flag[i] <= 1'b0;
            end
        end

        // a requested clear takes effect unless a new event arrived
        assert_clear_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr[i]) && !$past(set[i])) |-> !flag[i]);
    end

endmodule

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl
    import lpta_pkg::*;
#(
    parameter int HOLD_W   = 16,
    parameter int TURN_W   = 8,
    parameter int LISTEN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                esc_tick,
    input  logic                pkt_done,
    input  logic                pkt_needs_ta,
    input  logic [HOLD_W-1:0]   hold_count,
    input  logic [TURN_W-1:0]   turn_limit,
    input  logic [LISTEN_W-1:0] listen_limit,
    input  logic                link_reversed,
    input  logic                rx_lp_mode,
    input  logic                rx_data_valid,
    input  logic [1:0]          status_clr,
    output logic                turn_req,
    output logic                busy,
    output logic                xfer_done,
    output logic                turn_expired,
    output logic                listen_expired
);

    localparam int CNT_W = max3(HOLD_W, TURN_W, LISTEN_W);

    lpta_phase_e            phase;
    logic                   cnt_clr;
    logic                   cnt_step;
    logic                   at_limit;
    logic                   turn_expire;
    logic                   listen_expire;
    logic [CNT_W-1:0]       limit_sel;
    logic [STATUS_BITS-1:0] st_set;
    logic [STATUS_BITS-1:0] st_flag;

    // one shared counter: its compare value follows the active phase
    always_comb begin
        unique case (phase)
            PH_IDLE:   limit_sel = '0;
            PH_HOLD:   limit_sel = CNT_W'(hold_count);
            PH_TURN:   limit_sel = CNT_W'(turn_limit);
            PH_LISTEN: limit_sel = CNT_W'(listen_limit);
        endcase
    end

    lpta_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .esc_tick      (esc_tick),
        .pkt_done      (pkt_done),
        .pkt_needs_ta  (pkt_needs_ta),
        .link_reversed (link_reversed),
        .rx_lp_mode    (rx_lp_mode),
        .rx_data_valid (rx_data_valid),
        .at_limit      (at_limit),
        .phase         (phase),
        .cnt_clr       (cnt_clr),
        .cnt_step      (cnt_step),
        .turn_req      (turn_req),
        .busy          (busy),
        .xfer_done     (xfer_done),
        .turn_expire   (turn_expire),
        .listen_expire (listen_expire)
    );

    lpta_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .step     (cnt_step),
        .limit    (limit_sel),
        .at_limit (at_limit)
    );

    always_comb begin
        st_set            = '0;
        st_set[ST_TURN]   = turn_expire;
        st_set[ST_LISTEN] = listen_expire;
    end

    lpta_sticky_status #(.N(STATUS_BITS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .clr   (status_clr),
        .flag  (st_flag)
    );

    assign turn_expired   = st_flag[ST_TURN];
    assign listen_expired = st_flag[ST_LISTEN];

    // a sequence only starts from a qualified strobe
    assert_start_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pkt_done && pkt_needs_ta));

    // the request is preceded by a busy hold phase
    assert_req_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(turn_req) |-> $past(busy));

    // the request falls either because the direction changed or it timed out
    assert_req_drop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(turn_req) |-> ($past(link_reversed) || turn_expired));

    // a turnaround expiry leaves the block idle
    assert_turn_expiry_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(turn_expired) |-> (!busy && !turn_req && !xfer_done));

    // a receive expiry only follows an edge in receive mode without data
    assert_listen_expiry_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(listen_expired) |-> ($past(rx_lp_mode && !rx_data_valid) && !busy));

    // completion coincides with idle and lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && !turn_req) ##1 !xfer_done);

    // status bits stay set when no clear is written
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(turn_expired) && !$past(status_clr[0])) |-> turn_expired);

endmodule

// File: tb/lp_turnaround_ctrl_test.sv
`timescale 1ns/1ps
module lp_turnaround_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esc_tick = 1'b0;
    logic        pkt_done = 1'b0;
    logic        pkt_needs_ta = 1'b0;
    logic [15:0] hold_count = '0;
    logic [7:0]  turn_limit = '0;
    logic [15:0] listen_limit = '0;
    logic        link_reversed = 1'b0;
    logic        rx_lp_mode = 1'b0;
    logic        rx_data_valid = 1'b0;
    logic [1:0]  status_clr = '0;
    logic        turn_req, busy, xfer_done, turn_expired, listen_expired;

    always #2.5 clk = ~clk;

    lp_turnaround_ctrl uut (
        .clk(clk), .rst_n(rst_n), .esc_tick(esc_tick), .pkt_done(pkt_done),
        .pkt_needs_ta(pkt_needs_ta), .hold_count(hold_count), .turn_limit(turn_limit),
        .listen_limit(listen_limit), .link_reversed(link_reversed), .rx_lp_mode(rx_lp_mode),
        .rx_data_valid(rx_data_valid), .status_clr(status_clr), .turn_req(turn_req),
        .busy(busy), .xfer_done(xfer_done), .turn_expired(turn_expired),
        .listen_expired(listen_expired)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // expectation state (0 idle, 1 hold, 2 turn, 3 listen)
    int mph = 0;
    int mcnt = 0;
    bit m_done = 0, m_tf = 0, m_lf = 0;
    int c_hold = 0, c_turn = 0, c_listen = 0;
    int mm[5];
    int mm_act[5];
    int mm_exp[5];

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp(int i, logic act, bit exp);
        if (act !== exp) begin
            if (mm[i] == 0) begin
                mm_act[i] = int'(act);
                mm_exp[i] = int'(exp);
            end
            mm[i]++;
        end
    endtask

    function automatic bit next_flag(bit cur, bit set, bit clr);
        return set | (cur & !clr);
    endfunction

    // one clock edge: predict from the requirements, then compare outputs
    task automatic edge_step();
        int  nph = mph;
        int  ncnt = mcnt;
        bit  nd = 0, st = 0, sl = 0;
        case (mph)
            0: if (pkt_done && pkt_needs_ta) begin nph = 1; ncnt = 0; end
            1: if (mcnt == c_hold) begin nph = 2; ncnt = 0; end
               else if (esc_tick) ncnt++;
            2: if (link_reversed) begin nph = 3; ncnt = 0; end
               else if (mcnt == c_turn) begin nph = 0; st = 1; ncnt = 0; end
               else if (esc_tick) ncnt++;
            3: if (rx_lp_mode && rx_data_valid) begin nph = 0; nd = 1; ncnt = 0; end
               else if (!rx_lp_mode) ncnt = 0;
               else if (mcnt == c_listen) begin nph = 0; sl = 1; ncnt = 0; end
               else if (esc_tick) ncnt++;
            default: nph = 0;
        endcase
        m_tf   = next_flag(m_tf, st, status_clr[0]);
        m_lf   = next_flag(m_lf, sl, status_clr[1]);
        mph    = nph;
        mcnt   = ncnt;
        m_done = nd;
        @(posedge clk);
        #1;
        cmp(0, busy, mph != 0);
        cmp(1, turn_req, mph == 2);
        cmp(2, xfer_done, m_done);
        cmp(3, turn_expired, m_tf);
        cmp(4, listen_expired, m_lf);
    endtask

    task automatic report_trace();
        chk(mm[0] == 0, "R8 busy trace", mm_act[0], mm_exp[0]);
        chk(mm[1] == 0, "R2 R4 turn_req trace", mm_act[1], mm_exp[1]);
        chk(mm[2] == 0, "R7 xfer_done trace", mm_act[2], mm_exp[2]);
        chk(mm[3] == 0, "R5 R9 turn_expired trace", mm_act[3], mm_exp[3]);
        chk(mm[4] == 0, "R6 R9 listen_expired trace", mm_act[4], mm_exp[4]);
        for (int i = 0; i < 5; i++) mm[i] = 0;
    endtask

    // one sequence; a negative delay means the event never comes
    task automatic run_txn(int hold, int turn, int listen, int tp, int dir_dly,
                           int lp_dly, int val_dly, bit noise, bit clr_hold);
        int ta_cyc = 0, rx_cyc = 0, lp_cyc = 0, guard = 0;
        c_hold = hold; c_turn = turn; c_listen = listen;
        hold_count = 16'(hold); turn_limit = 8'(turn); listen_limit = 16'(listen);
        status_clr = clr_hold ? 2'b01 : 2'b00;
        pkt_done = 1'b1; pkt_needs_ta = 1'b1;
        esc_tick = ($urandom_range(tp - 1) == 0);
        edge_step();
        pkt_done = 1'b0;
        while (mph != 0 && guard < 5000) begin
            esc_tick = ($urandom_range(tp - 1) == 0);
            if (mph == 2) begin
                if (dir_dly >= 0 && ta_cyc >= dir_dly) link_reversed = 1'b1;
                ta_cyc++;
            end
            if (mph == 3) begin
                if (rx_cyc >= lp_dly) rx_lp_mode = 1'b1;
                rx_cyc++;
                if (rx_lp_mode) begin
                    if (val_dly >= 0 && lp_cyc >= val_dly) rx_data_valid = 1'b1;
                    lp_cyc++;
                end
            end
            pkt_done = noise && ($urandom_range(3) == 0);   // R8: strobes while busy
            edge_step();
            guard++;
        end
        chk(guard < 5000, "R4 sequence ended", guard, 5000);
        if (clr_hold) chk(turn_expired === 1'b1, "R9 set wins over clear", int'(turn_expired), 1);
        pkt_done = 1'b0; link_reversed = 1'b0; rx_lp_mode = 1'b0; rx_data_valid = 1'b0;
        esc_tick = 1'b1;
        edge_step();
        edge_step();
        status_clr = 2'b11;
        edge_step();
        status_clr = 2'b00;
        edge_step();
        report_trace();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int i = 0; i < 5; i++) begin mm[i] = 0; mm_act[i] = 0; mm_exp[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(busy === 1'b0 && turn_req === 1'b0, "R1 busy/turn_req at reset",
            int'(busy) + int'(turn_req), 0);
        chk(xfer_done === 1'b0 && turn_expired === 1'b0 && listen_expired === 1'b0,
            "R1 done/status at reset", int'(xfer_done) + int'(turn_expired) + int'(listen_expired), 0);
        rst_n = 1'b1;
        edge_step();
        report_trace();

        // R3: unqualified strobe is ignored
        pkt_done = 1'b1; pkt_needs_ta = 1'b0;
        edge_step(); edge_step(); edge_step();
        pkt_done = 1'b0;
        chk(busy === 1'b0, "R3 unqualified strobe ignored", int'(busy), 0);
        report_trace();

        // R2/R5: zero hold, zero turn limit, direction never changes
        run_txn(0, 0, 0, 1, -1, 0, 0, 0, 0);
        // R9: clear held during a forced expiry
        run_txn(1, 0, 0, 1, -1, 0, 0, 0, 1);
        // R7: fast path, everything immediate
        run_txn(0, 3, 3, 1, 0, 0, 0, 1, 0);
        // R6: receive data never valid, late receive mode
        run_txn(2, 4, 3, 2, 1, 4, -1, 1, 0);
        // R5: direction arrives exactly on the limit edge (dir wins)
        run_txn(0, 2, 2, 1, 2, 0, 1, 0, 0);
        // R2: long hold with a tick every cycle
        run_txn(1000, 5, 5, 1, 3, 1, 2, 1, 0);

        // random sequences
        for (int n = 0; n < 60; n++) begin
            int dd, vd;
            dd = ($urandom_range(3) == 0) ? -1 : int'($urandom_range(12));
            vd = ($urandom_range(3) == 0) ? -1 : int'($urandom_range(12));
            run_txn(int'($urandom_range(6)), int'($urandom_range(5)), int'($urandom_range(5)),
                    int'($urandom_range(1, 3)), dd, int'($urandom_range(4)), vd,
                    1'($urandom_range(1)), 0);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule